// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one channel of a multi-channel event timer. It watches a shared, free-running 64-bit main count and raises an event when the count reaches a target formed from its comparator. The channel runs once or repeats, compares across the full 64 bits or only the low 32 bits, and signals an interrupt as a one-cycle pulse or as a level. Software reaches the channel through two registers, configuration and comparator. Writes to them arrive as 64-bit data with a per-byte strobe.

Each event produces a one-cycle status-set pulse for the shared interrupt status register. The current state of this channel's status bit comes back on `status_in`. In level mode the interrupt line follows that bit. The main count, the shared status register, address decode and interrupt routing all sit outside the channel.

Top module: `tmr_channel`

## Requirements
- R1: After reset the comparator reads all ones, the configuration reads 0x30 (bit 4 = periodic capable, bit 5 = 64-bit capable), and `irq` and `status_set` are low.
- R2: A configuration write changes only the writable bits: 1 = level type, 2 = interrupt enable, 3 = periodic, 8 = 32-bit mode. Every other bit keeps its value. Byte i of the data lands only when strobe bit i is set.
- R3: In 64-bit one-shot mode the channel fires once, when the main count equals the comparator. `status_set` is high for one cycle, in the cycle after the main count held that value.
- R4: In 32-bit mode the target is the current count with its low 32 bits replaced by the comparator. If that value is below the current count, 2^32 is added.
- R5: While 32-bit mode is set, the upper 32 bits of the comparator and of the period read as zero. Setting the mode truncates both.
- R6: In 32-bit one-shot mode, if the target lies beyond the next 32-bit wrap of the count, an extra event fires when the low 32 bits reach zero. The real target then fires as well.
- R7: With the interrupt enable clear, events still pulse `status_set`, but `irq` stays low.
- R8: A comparator write while the periodic bit is set also loads the period. In periodic mode, each event advances the target and the comparator by the period, and the channel stays armed.
- R9: In level mode `irq` stays high while `status_in` is high and the enable is set. Clearing the level-type bit drops `irq` in the cycle after the write.
- R10: In edge mode, setting the interrupt enable while `status_in` is high gives a one-cycle `irq` pulse right after the write.
- R11: The channel arms only while `global_en` is high. It re-arms on each register write and on the rising edge of `global_en`. It fires no events while `global_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_count | input | 64 | Shared main count value |
| global_en | input | 1 | Global timer enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_wstrb | input | 8 | Configuration byte enables |
| cmp_we | input | 1 | Comparator write strobe |
| cmp_wdata | input | 64 | Comparator write data |
| cmp_wstrb | input | 8 | Comparator byte enables |
| status_in | input | 1 | This channel's bit in the shared status register |
| irq | output | 1 | Interrupt line |
| status_set | output | 1 | One-cycle request to set the status bit |
| cfg_rd | output | 64 | Configuration register contents |
| cmp_rd | output | 64 | Comparator register contents |

## Verification
The hardest situations to reach are the ones near a 32-bit wrap of the main count: the target that is pushed forward by 2^32, the extra event at the wrap, and periodic events that cross it. A free-running count would take billions of cycles to get there. Because the main count is a port, the stimulus enables the channel with the count placed a few ticks below a 32-bit boundary and then steps it by one per cycle. It records the count value at every event and compares those values with the targets computed from the requirements.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 64;
  localparam int HALF_W = CNT_W / 2;
  localparam int NBYTES = CNT_W / 8;

  typedef logic [CNT_W-1:0] word_t;

  // configuration bit positions
  localparam int B_LVL  = 1;
  localparam int B_IEN  = 2;
  localparam int B_PER  = 3;
  localparam int B_PCAP = 4;
  localparam int B_SCAP = 5;
  localparam int B_M32  = 8;

  localparam word_t CFG_WMASK = word_t'((1 << B_LVL) | (1 << B_IEN) | (1 << B_PER) | (1 << B_M32));
  localparam word_t CFG_RST   = word_t'((1 << B_PCAP) | (1 << B_SCAP));

  function automatic word_t merge_bytes(word_t old_v, word_t new_v, logic [NBYTES-1:0] strb);
    word_t r;
    r = old_v;
    for (int i = 0; i < NBYTES; i++)
      if (strb[i]) r[8*i +: 8] = new_v[8*i +: 8];
    return r;
  endfunction

  function automatic word_t low_half(word_t v);
    return {{HALF_W{1'b0}}, v[HALF_W-1:0]};
  endfunction

  // first count value whose low half is zero, strictly after c
  function automatic word_t next_wrap(word_t c);
    return {c[CNT_W-1:HALF_W] + 1'b1, {HALF_W{1'b0}}};
  endfunction

  function automatic word_t match_target(logic m32, word_t c, word_t cmp);
    word_t t;
    if (!m32) return cmp;
    t = {c[CNT_W-1:HALF_W], cmp[HALF_W-1:0]};
    if (t < c) t = t + (word_t'(1) << HALF_W);
    return t;
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  word_t             cfg_wdata,
  input  logic [NBYTES-1:0] cfg_wstrb,
  input  logic              cmp_we,
  input  word_t             cmp_wdata,
  input  logic [NBYTES-1:0] cmp_wstrb,
  input  logic              adv_en,
  input  word_t             adv_val,
  output word_t             cfg_q,
  output word_t             cfg_d,
  output word_t             cmp_q,
  output word_t             cmp_d,
  output word_t             per_q
);
  word_t cmp_in, per_d;
  logic  m32_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we)
      cfg_d = (cfg_q & ~CFG_WMASK) | (merge_bytes(cfg_q, cfg_wdata, cfg_wstrb) & CFG_WMASK);
    m32_d  = cfg_d[B_M32];
    cmp_in = merge_bytes(cmp_q, cmp_wdata, cmp_wstrb);
    if (cmp_we)      cmp_d = cmp_in;
    else if (adv_en) cmp_d = adv_val;
    else             cmp_d = cmp_q;
    per_d = (cmp_we && cfg_d[B_PER]) ? cmp_in : per_q;
    if (m32_d) begin
      cmp_d = low_half(cmp_d);
      per_d = low_half(per_d);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
      cmp_q <= '1;
      per_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      cmp_q <= cmp_d;
      per_q <= per_d;
    end
  end

  assert_cfg_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> ((cfg_q ^ $past(cfg_q)) & ~CFG_WMASK) == '0);

  assert_trunc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[B_M32] |-> (cmp_q[CNT_W-1:HALF_W] == '0 && per_q[CNT_W-1:HALF_W] == '0));
endmodule

// File: rtl/tmr_arm.sv
module tmr_arm
  import tmr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t cnt,
  input  logic  gen,
  input  logic  rearm,
  input  logic  m32,
  input  logic  per,
  input  word_t cmp_d,
  input  word_t per_q,
  output logic  fire,
  output logic  wrap_fire,
  output logic  adv_en,
  output word_t adv_val
);
  word_t arm_pt, tgt, new_tgt, wrap_pt;
  logic  armed, wrap_pend, split;

  always_comb begin
    new_tgt   = match_target(m32, cnt, cmp_d);
    wrap_pt   = next_wrap(cnt);
    split     = m32 & ~per & (new_tgt > wrap_pt);
    fire      = armed & gen & (cnt == arm_pt);
    wrap_fire = fire & wrap_pend;
    adv_val   = tgt + per_q;
    adv_en    = fire & per & ~wrap_pend & ~rearm;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      wrap_pend <= 1'b0;
      arm_pt    <= '0;
      tgt       <= '0;
    end else if (!gen) begin
      armed     <= 1'b0;
      wrap_pend <= 1'b0;
    end else if (rearm) begin
      armed     <= 1'b1;
      tgt       <= new_tgt;
      arm_pt    <= split ? wrap_pt : new_tgt;
      wrap_pend <= split;
    end else if (fire) begin
      if (wrap_pend) begin
        wrap_pend <= 1'b0;
        arm_pt    <= tgt;
      end else if (per) begin
        tgt    <= adv_val;
        arm_pt <= adv_val;
      end else begin
        armed <= 1'b0;
      end
    end
  end

  assert_oneshot_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !per && !wrap_pend && !rearm) |=> !armed);

  assert_wrap_then_real_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_fire && !rearm) |=> (armed && !wrap_pend && arm_pt == tgt));

  assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !gen |=> !armed);
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic ien_d,
  input  logic lvl_d,
  input  logic ien_q,
  input  logic status_in,
  output logic irq,
  output logic status_set
);
  logic en_rise, irq_d;

  always_comb begin
    en_rise = ien_d & ~ien_q;
    irq_d   = ien_d & (lvl_d ? (status_in | fire) : (fire | (en_rise & status_in)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      status_set <= 1'b0;
    end else begin
      irq        <= irq_d;
      status_set <= fire;
    end
  end

  assert_level_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_d && lvl_d && status_in) |=> irq);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  main_count,
  input  logic              global_en,
  input  logic              cfg_we,
  input  logic [CNT_W-1:0]  cfg_wdata,
  input  logic [NBYTES-1:0] cfg_wstrb,
  input  logic              cmp_we,
  input  logic [CNT_W-1:0]  cmp_wdata,
  input  logic [NBYTES-1:0] cmp_wstrb,
  input  logic              status_in,
  output logic              irq,
  output logic              status_set,
  output logic [CNT_W-1:0]  cfg_rd,
  output logic [CNT_W-1:0]  cmp_rd
);
  word_t cfg_q, cfg_d, cmp_q, cmp_d, per_q, adv_val;
  logic  gen_q, rearm, fire, wrap_fire, adv_en;

  always_ff @(posedge clk) begin
    if (!rst_n) gen_q <= 1'b0;
    else        gen_q <= global_en;
  end

  assign rearm = global_en & (cfg_we | cmp_we | ~gen_q);

  tmr_regs u_regs (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .cfg_wstrb, .cmp_we, .cmp_wdata, .cmp_wstrb,
    .adv_en, .adv_val, .cfg_q, .cfg_d, .cmp_q, .cmp_d, .per_q
  );

  tmr_arm u_arm (
    .clk, .rst_n, .cnt(main_count), .gen(global_en), .rearm,
    .m32(cfg_d[B_M32]), .per(cfg_d[B_PER]), .cmp_d, .per_q,
    .fire, .wrap_fire, .adv_en, .adv_val
  );

  tmr_irq u_irq (
    .clk, .rst_n, .fire, .ien_d(cfg_d[B_IEN]), .lvl_d(cfg_d[B_LVL]),
    .ien_q(cfg_q[B_IEN]), .status_in, .irq, .status_set
  );

  assign cfg_rd = cfg_q;
  assign cmp_rd = cmp_q;

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cfg_rd[B_IEN]);
endmodule

// File: tb/test_tmr_channel.sv
module test_tmr_channel;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        m32;
    logic        per;
    logic        ien;
    logic [63:0] start;
    logic [63:0] cmp;
    logic [15:0] cyc;
    logic [7:0]  n_ev;
    logic [63:0] f0;
    logic [63:0] f1;
    logic [63:0] fcmp;
    logic [7:0]  n_irq;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    // R3: 64-bit one-shot
    '{1'b0, 1'b0, 1'b1, 64'd100, 64'd110, 16'd30, 8'd1, 64'd110, 64'd0, 64'd110, 8'd1, 8'd3},
    // R4: 32-bit, target in same 4G window
    '{1'b1, 1'b0, 1'b1, 64'h1_0000_0010, 64'h20, 16'd30, 8'd1, 64'h1_0000_0020, 64'd0, 64'h20, 8'd1, 8'd4},
    // R6: 32-bit one-shot crossing a wrap: extra event then real match
    '{1'b1, 1'b0, 1'b1, 64'h0_FFFF_FFF0, 64'h5, 16'd40, 8'd2, 64'h1_0000_0000, 64'h1_0000_0005, 64'h5, 8'd2, 8'd6},
    // R8: 64-bit periodic, period 5
    '{1'b0, 1'b1, 1'b1, 64'd0, 64'd5, 16'd20, 8'd3, 64'd5, 64'd10, 64'd20, 8'd3, 8'd8},
    // R8: 32-bit periodic across wrap, comparator truncated
    '{1'b1, 1'b1, 1'b1, 64'hFFFF_FFF8, 64'h2, 16'd16, 8'd3, 64'h1_0000_0002, 64'h1_0000_0004, 64'h8, 8'd3, 8'd8},
    // R7: enable clear, status only
    '{1'b0, 1'b0, 1'b0, 64'd300, 64'd305, 16'd15, 8'd1, 64'd305, 64'd0, 64'd305, 8'd0, 8'd7}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] main_count = '0;
  logic        global_en = 1'b0;
  logic        cfg_we = 1'b0, cmp_we = 1'b0;
  logic [63:0] cfg_wdata = '0, cmp_wdata = '0;
  logic [7:0]  cfg_wstrb = '0, cmp_wstrb = '0;
  logic        sts = 1'b0, sts_clr = 1'b0, sts_force = 1'b0;
  logic        irq, status_set;
  logic [63:0] cfg_rd, cmp_rd;

  int checks = 0, errors = 0;
  int ev_n, irq_n;
  logic [63:0] fc0, fc1;

  always #(CLK_PERIOD/2) clk = ~clk;

  // shared status register model
  always @(posedge clk)
    if (!rst_n || sts_clr) sts <= 1'b0;
    else if (status_set || sts_force) sts <= 1'b1;

  tmr_channel i_tmr_channel (
    .clk, .rst_n, .main_count, .global_en, .cfg_we, .cfg_wdata, .cfg_wstrb,
    .cmp_we, .cmp_wdata, .cmp_wstrb, .status_in(sts), .irq, .status_set, .cfg_rd, .cmp_rd
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; global_en = 1'b0; cfg_we = 1'b0; cmp_we = 1'b0;
    sts_clr = 1'b0; sts_force = 1'b0; main_count = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_cfg(input logic [63:0] d, input logic [7:0] s);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d; cfg_wstrb = s;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_cmp(input logic [63:0] d, input logic [7:0] s);
    @(negedge clk); cmp_we = 1'b1; cmp_wdata = d; cmp_wstrb = s;
    @(negedge clk); cmp_we = 1'b0;
  endtask

  // step the count by one per cycle, recording the count value seen at each event
  task automatic watch(input int n);
    ev_n = 0; irq_n = 0; fc0 = '0; fc1 = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (status_set) begin
        if (ev_n == 0) fc0 = main_count;
        if (ev_n == 1) fc1 = main_count;
        ev_n++;
      end
      if (irq) irq_n++;
      main_count = main_count + 64'd1;
    end
  endtask

  function automatic logic [63:0] mk_cfg(logic lvl, logic ien, logic per, logic m32);
    return (64'(lvl) << 1) | (64'(ien) << 2) | (64'(per) << 3) | (64'(m32) << 8);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    @(negedge clk);
    chk(cfg_rd == 64'h30, "R1 cfg", cfg_rd, 64'h30);
    chk(cmp_rd == '1, "R1 cmp", cmp_rd, '1);
    chk(irq == 1'b0, "R1 irq", 64'(irq), 0);
    chk(status_set == 1'b0, "R1 status_set", 64'(status_set), 0);

    // R2 write mask and byte strobes; R5 truncation on entering 32-bit mode
    wr_cfg('1, 8'hFF);
    chk(cfg_rd == 64'h13E, "R2 mask", cfg_rd, 64'h13E);
    chk(cmp_rd == 64'hFFFF_FFFF, "R5 cmp truncated", cmp_rd, 64'hFFFF_FFFF);
    wr_cfg('0, 8'h01);
    chk(cfg_rd == 64'h130, "R2 strobe", cfg_rd, 64'h130);
    wr_cmp(64'hAABB_CCDD_1122_3344, 8'hF0);
    chk(cmp_rd == 64'hFFFF_FFFF, "R5 high half ignored", cmp_rd, 64'hFFFF_FFFF);

    // vector table: R3 R4 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      do_reset();
      wr_cfg(mk_cfg(1'b0, VECS[v].ien, VECS[v].per, VECS[v].m32), 8'hFF);
      wr_cmp(VECS[v].cmp, 8'hFF);
      @(negedge clk); main_count = VECS[v].start; global_en = 1'b1;
      watch(int'(VECS[v].cyc));
      chk(ev_n == int'(VECS[v].n_ev), $sformatf("R%0d events v%0d", VECS[v].req, v), 64'(ev_n), 64'(VECS[v].n_ev));
      chk(fc0 == VECS[v].f0, $sformatf("R%0d first v%0d", VECS[v].req, v), fc0, VECS[v].f0);
      if (VECS[v].n_ev > 1)
        chk(fc1 == VECS[v].f1, $sformatf("R%0d second v%0d", VECS[v].req, v), fc1, VECS[v].f1);
      chk(irq_n == int'(VECS[v].n_irq), $sformatf("R%0d irq v%0d", VECS[v].req, v), 64'(irq_n), 64'(VECS[v].n_irq));
      chk(cmp_rd == VECS[v].fcmp, $sformatf("R%0d cmp v%0d", VECS[v].req, v), cmp_rd, VECS[v].fcmp);
    end

    // R11: no events while global enable is low
    do_reset();
    wr_cfg(mk_cfg(1'b0, 1'b1, 1'b0, 1'b0), 8'hFF);
    wr_cmp(64'd10, 8'hFF);
    main_count = '0;
    watch(20);
    chk(ev_n == 0, "R11 idle", 64'(ev_n), 0);

    // R9: level interrupt holds until status cleared
    do_reset();
    wr_cfg(mk_cfg(1'b1, 1'b1, 1'b0, 1'b0), 8'hFF);
    wr_cmp(64'd10, 8'hFF);
    @(negedge clk); main_count = '0; global_en = 1'b1;
    watch(15);
    chk(ev_n == 1, "R9 event", 64'(ev_n), 1);
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R9 level held", 64'(irq), 1);
    sts_clr = 1'b1; @(negedge clk); sts_clr = 1'b0;
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R9 low after clear", 64'(irq), 0);
    sts_force = 1'b1; @(negedge clk); sts_force = 1'b0;
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R9 level from status", 64'(irq), 1);
    wr_cfg(mk_cfg(1'b0, 1'b1, 1'b0, 1'b0), 8'hFF);
    chk(irq == 1'b0, "R9 level bit cleared", 64'(irq), 0);

    // R10: enabling with status active gives one pulse
    do_reset();
    sts_force = 1'b1; @(negedge clk); sts_force = 1'b0;
    wr_cfg(mk_cfg(1'b0, 1'b0, 1'b0, 1'b0), 8'hFF);
    chk(irq == 1'b0, "R10 disabled", 64'(irq), 0);
    wr_cfg(mk_cfg(1'b0, 1'b1, 1'b0, 1'b0), 8'hFF);
    chk(irq == 1'b1, "R10 pulse", 64'(irq), 1);
    @(negedge clk);
    chk(irq == 1'b0, "R10 pulse ends", 64'(irq), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule